// File: doc/BRIEF.md
# Context-Tagged Translation Cache with Power-of-Two Fragments

This block is a small, fully associative address translation cache for a GPU memory unit. A client presents a 4-bit context number and a 40-bit virtual address, together with the direction of the access. One clock later the block answers with one of three outcomes: hit, permission fault or miss. On a hit or a fault it also returns the translated physical address, the read and write permissions, the system-memory flag and the CPU-snoop flag. Context 0 is reserved for the system context and is otherwise treated like any other context.

Each cached entry spans a naturally aligned region of 2^(12 + f) bytes, where f is a 5-bit fragment code supplied with the entry. Address bits at and above position 12 + f select the entry. Bits below that position pass straight from the request to the physical address. A page walker outside this block writes new entries through a refill port. Software can drop every entry of one context in a single cycle. No operation removes a single entry.

Top module: `ctx_frag_tlb`

## Requirements
- R1: After reset no entry is valid. Every lookup then reports a miss, and the response outputs hold zero until a lookup is answered.
- R2: `rsp_valid` rises exactly one cycle after `lk_valid` is sampled high. When `rsp_valid` is low, hit and fault are both low.
- R3: A lookup matches an entry only when the entry is valid, its context equals `lk_ctx`, and virtual address bits from 12+f up to 39 are equal, where f is the entry's fragment code. A stored entry never matches a lookup from another context.
- R4: An entry with fragment code f covers 2^(12+f) bytes, so f=0 covers 4 KiB and f=1 covers 8 KiB. An address one region further on misses. Codes of 28 and above cover the whole 40-bit space.
- R5: On a hit or a fault, `rsp_paddr` bits at and above 12+f come from the entry's physical base. The lower bits come from the request's virtual address.
- R6: On a hit or a fault, the entry's read, write, system and snoop flags appear on `rsp_rd`, `rsp_wr`, `rsp_sys` and `rsp_snoop`. On a miss these flags and `rsp_paddr` are zero.
- R7: If a lookup matches but its access is not allowed, the response reports a fault and not a hit. A read needs the read flag and a write (`lk_write`=1) needs the write flag.
- R8: A flush of context c invalidates every entry tagged c in one cycle. Entries of other contexts are kept.
- R9: A lookup issued in the same cycle as a flush of its own context reports a miss. A flush of a different context does not affect it.
- R10: A refill is written into the lowest-numbered invalid entry. If all entries are valid, it goes to the entry named by a victim pointer. The pointer starts at 0 after reset and advances by one, wrapping, on each such refill.
- R11: A lookup in the same cycle as a refill sees the contents from before that refill. A refill in the same cycle as a flush is kept, even when its context is the one being flushed.
- R12: When several entries match a lookup, the lowest-numbered one supplies the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_ctx | input | 4 | Lookup context number |
| lk_vaddr | input | 40 | Lookup virtual address |
| lk_write | input | 1 | 1 for a write access, 0 for a read |
| fill_valid | input | 1 | Refill request |
| fill_ctx | input | 4 | Context of the new entry |
| fill_vaddr | input | 40 | Virtual address covered by the new entry |
| fill_pbase | input | 28 | Physical base, address bits 39 to 12 |
| fill_frag | input | 5 | Fragment code, region size is 2^(12+code) bytes |
| fill_rd | input | 1 | Read allowed |
| fill_wr | input | 1 | Write allowed |
| fill_sys | input | 1 | Page lives in system memory |
| fill_snoop | input | 1 | Access snoops the CPU cache |
| flush_valid | input | 1 | Flush request |
| flush_ctx | input | 4 | Context to flush |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation hit with permission |
| rsp_fault | output | 1 | Match found, access not allowed |
| rsp_paddr | output | 40 | Translated physical address |
| rsp_rd | output | 1 | Read flag of the matched entry |
| rsp_wr | output | 1 | Write flag of the matched entry |
| rsp_sys | output | 1 | System flag of the matched entry |
| rsp_snoop | output | 1 | Snoop flag of the matched entry |

## Verification
A lookup can fall in the same cycle as a flush, and it can also fall in the same cycle as a refill. Both collisions arise in the directed part of the bench, where the colliding context is either the lookup's own or a different one. They also arise in a long mixed run over a narrow range of contexts and addresses. In every case the answer is judged against a behavioural reference model. That model resolves the lookup against the contents from before the edge and treats a same-context flush as a miss. It then applies the flush and the refill in the order the requirements give.

// File: rtl/ctx_frag_tlb.sv
module ctx_frag_tlb #(
  parameter int ENTRIES = 16,
  parameter int VA_W    = 40,
  parameter int CTX_W   = 4,
  parameter int FRAG_W  = 5,
  parameter int PG_SH   = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  lk_valid,
  input  logic [CTX_W-1:0]      lk_ctx,
  input  logic [VA_W-1:0]       lk_vaddr,
  input  logic                  lk_write,
  input  logic                  fill_valid,
  input  logic [CTX_W-1:0]      fill_ctx,
  input  logic [VA_W-1:0]       fill_vaddr,
  input  logic [VA_W-PG_SH-1:0] fill_pbase,
  input  logic [FRAG_W-1:0]     fill_frag,
  input  logic                  fill_rd,
  input  logic                  fill_wr,
  input  logic                  fill_sys,
  input  logic                  fill_snoop,
  input  logic                  flush_valid,
  input  logic [CTX_W-1:0]      flush_ctx,
  output logic                  rsp_valid,
  output logic                  rsp_hit,
  output logic                  rsp_fault,
  output logic [VA_W-1:0]       rsp_paddr,
  output logic                  rsp_rd,
  output logic                  rsp_wr,
  output logic                  rsp_sys,
  output logic                  rsp_snoop
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int PN_W  = VA_W - PG_SH;

  logic [ENTRIES-1:0] e_val, e_rd, e_wr, e_sys, e_snp;
  logic [CTX_W-1:0]   e_ctx  [ENTRIES];
  logic [PN_W-1:0]    e_vpn  [ENTRIES];
  logic [PN_W-1:0]    e_ppn  [ENTRIES];
  logic [FRAG_W-1:0]  e_frag [ENTRIES];

  logic [ENTRIES-1:0] match;
  logic [IDX_W-1:0]   rr, victim, sel;
  logic               found, have_free, kill, take, perm_ok;
  logic [PN_W-1:0]    lk_vpn, sel_mask;

  function automatic logic [PN_W-1:0] keep_mask(input logic [FRAG_W-1:0] f);
    for (int b = 0; b < PN_W; b++) keep_mask[b] = (b >= int'(f));
  endfunction

  assign lk_vpn = lk_vaddr[VA_W-1:PG_SH];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = e_val[g] && (e_ctx[g] == lk_ctx) &&
                      (((e_vpn[g] ^ lk_vpn) & keep_mask(e_frag[g])) == '0);
  end

  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (match[i]) begin
        found = 1'b1;
        sel   = IDX_W'(i);
      end
  end

  always_comb begin
    have_free = 1'b0;
    victim    = rr;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!e_val[i]) begin
        have_free = 1'b1;
        victim    = IDX_W'(i);
      end
  end

  assign kill     = flush_valid && (flush_ctx == lk_ctx);
  assign take     = lk_valid && found && !kill;
  assign sel_mask = keep_mask(e_frag[sel]);
  assign perm_ok  = lk_write ? e_wr[sel] : e_rd[sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
      rsp_rd    <= 1'b0;
      rsp_wr    <= 1'b0;
      rsp_sys   <= 1'b0;
      rsp_snoop <= 1'b0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= take && perm_ok;
      rsp_fault <= take && !perm_ok;
      rsp_paddr <= take ? {(e_ppn[sel] & sel_mask) | (lk_vpn & ~sel_mask),
                           lk_vaddr[PG_SH-1:0]} : '0;
      rsp_rd    <= take && e_rd[sel];
      rsp_wr    <= take && e_wr[sel];
      rsp_sys   <= take && e_sys[sel];
      rsp_snoop <= take && e_snp[sel];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rr <= '0;
    else if (fill_valid && !have_free)
      rr <= (rr == IDX_W'(ENTRIES - 1)) ? '0 : rr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_val <= '0;
      e_rd  <= '0;
      e_wr  <= '0;
      e_sys <= '0;
      e_snp <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        e_ctx[i]  <= '0;
        e_vpn[i]  <= '0;
        e_ppn[i]  <= '0;
        e_frag[i] <= '0;
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (fill_valid && victim == IDX_W'(i)) begin
          e_val[i]  <= 1'b1;
          e_ctx[i]  <= fill_ctx;
          e_vpn[i]  <= fill_vaddr[VA_W-1:PG_SH];
          e_ppn[i]  <= fill_pbase;
          e_frag[i] <= fill_frag;
          e_rd[i]   <= fill_rd;
          e_wr[i]   <= fill_wr;
          e_sys[i]  <= fill_sys;
          e_snp[i]  <= fill_snoop;
        end else if (flush_valid && e_ctx[i] == flush_ctx) begin
          e_val[i]  <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/ctx_frag_tlb_chk.sv
module ctx_frag_tlb_chk #(
  parameter int VA_W  = 40,
  parameter int CTX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic [CTX_W-1:0] lk_ctx,
  input logic [11:0]      lk_off,
  input logic             lk_write,
  input logic             flush_valid,
  input logic [CTX_W-1:0] flush_ctx,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic             rsp_fault,
  input logic [VA_W-1:0]  rsp_paddr,
  input logic             rsp_rd,
  input logic             rsp_wr,
  input logic             rsp_sys,
  input logic             rsp_snoop
);
  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);                                              // R2
  AST_NO_RSP_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid);                                            // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !rsp_hit && !rsp_fault);                               // R2
  AST_HIT_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_hit && rsp_fault));                                             // R7
  AST_FAULT_PERM: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> ($past(lk_write) ? !rsp_wr : !rsp_rd));                 // R7
  AST_HIT_PERM: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> ($past(lk_write) ? rsp_wr : rsp_rd));                     // R7
  AST_FLUSH_KILLS_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && flush_valid && flush_ctx == lk_ctx |=> !rsp_hit && !rsp_fault); // R9
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_hit && !rsp_fault |-> rsp_paddr == '0 && !rsp_rd && !rsp_wr &&
                               !rsp_sys && !rsp_snoop);                   // R6
  AST_PAGE_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_paddr[11:0] == $past(lk_off));                        // R5
endmodule

bind ctx_frag_tlb ctx_frag_tlb_chk #(.VA_W(VA_W), .CTX_W(CTX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ctx(lk_ctx),
  .lk_off(lk_vaddr[11:0]), .lk_write(lk_write), .flush_valid(flush_valid),
  .flush_ctx(flush_ctx), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
  .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr), .rsp_rd(rsp_rd),
  .rsp_wr(rsp_wr), .rsp_sys(rsp_sys), .rsp_snoop(rsp_snoop));

// File: tb/ctx_frag_tlb_test.sv
`timescale 1ns/1ps
module ctx_frag_tlb_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic        lk_valid, lk_write, fill_valid, fill_rd, fill_wr, fill_sys, fill_snoop, flush_valid;
  logic [3:0]  lk_ctx, fill_ctx, flush_ctx;
  logic [39:0] lk_vaddr, fill_vaddr;
  logic [27:0] fill_pbase;
  logic [4:0]  fill_frag;
  logic        rsp_valid, rsp_hit, rsp_fault, rsp_rd, rsp_wr, rsp_sys, rsp_snoop;
  logic [39:0] rsp_paddr;

  ctx_frag_tlb uut (.*);

  int    vectors = 0, fails = 0, cycles = 0;
  string cur_req = "R1";

  bit          m_val [16];
  logic [3:0]  m_ctx [16];
  logic [39:0] m_va  [16];
  logic [39:0] m_pa  [16];
  logic [4:0]  m_fr  [16];
  bit          m_rd [16], m_wr [16], m_sy [16], m_sn [16];
  int          m_rr;

  logic        e_v, e_h, e_f, e_r, e_w, e_s, e_n;
  logic [39:0] e_p;

  function automatic logic [39:0] hi_mask(input logic [4:0] f);
    for (int b = 0; b < 40; b++) hi_mask[b] = (b >= 12 + int'(f));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) m_val[i] = 0;
      m_rr = 0;
      {e_v, e_h, e_f, e_r, e_w, e_s, e_n} = '0;
      e_p = '0;
    end else begin
      int hit_i, vic;
      logic [39:0] hm;
      e_v = lk_valid;
      {e_h, e_f, e_r, e_w, e_s, e_n} = '0;
      e_p = '0;
      hit_i = -1;
      if (lk_valid && !(flush_valid && flush_ctx == lk_ctx))
        for (int i = 0; i < 16; i++)
          if (hit_i < 0 && m_val[i] && m_ctx[i] == lk_ctx &&
              ((m_va[i] ^ lk_vaddr) & hi_mask(m_fr[i])) == 0) hit_i = i;
      if (hit_i >= 0) begin
        hm  = hi_mask(m_fr[hit_i]);
        e_p = (m_pa[hit_i] & hm) | (lk_vaddr & ~hm);
        e_r = m_rd[hit_i]; e_w = m_wr[hit_i]; e_s = m_sy[hit_i]; e_n = m_sn[hit_i];
        if (lk_write ? m_wr[hit_i] : m_rd[hit_i]) e_h = 1; else e_f = 1;
      end
      vic = -1;
      if (fill_valid) begin
        for (int i = 0; i < 16; i++) if (vic < 0 && !m_val[i]) vic = i;
        if (vic < 0) begin vic = m_rr; m_rr = (m_rr + 1) % 16; end
      end
      if (flush_valid)
        for (int i = 0; i < 16; i++) if (m_ctx[i] == flush_ctx) m_val[i] = 0;
      if (fill_valid) begin
        m_val[vic] = 1; m_ctx[vic] = fill_ctx; m_va[vic] = fill_vaddr;
        m_pa[vic] = {fill_pbase, 12'h000}; m_fr[vic] = fill_frag;
        m_rd[vic] = fill_rd; m_wr[vic] = fill_wr; m_sy[vic] = fill_sys; m_sn[vic] = fill_snoop;
      end
    end
  end

  task automatic cmp(input string nm, input logic [39:0] act, input logic [39:0] exp);
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", cur_req, nm, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      vectors++;
      cmp("rsp_valid", 40'(rsp_valid), 40'(e_v));
      cmp("rsp_hit",   40'(rsp_hit),   40'(e_h));
      cmp("rsp_fault", 40'(rsp_fault), 40'(e_f));
      cmp("rsp_paddr", rsp_paddr, e_p);
      cmp("rsp_rd",    40'(rsp_rd),    40'(e_r));
      cmp("rsp_wr",    40'(rsp_wr),    40'(e_w));
      cmp("rsp_sys",   40'(rsp_sys),   40'(e_s));
      cmp("rsp_snoop", 40'(rsp_snoop), 40'(e_n));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<=100000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic clr();
    lk_valid = 0; lk_write = 0; lk_ctx = 0; lk_vaddr = 0;
    fill_valid = 0; fill_ctx = 0; fill_vaddr = 0; fill_pbase = 0; fill_frag = 0;
    fill_rd = 0; fill_wr = 0; fill_sys = 0; fill_snoop = 0;
    flush_valid = 0; flush_ctx = 0;
  endtask
  task automatic tick(); @(negedge clk); clr(); endtask
  task automatic lk(input logic [3:0] c, input logic [39:0] va, input logic w);
    lk_valid = 1; lk_ctx = c; lk_vaddr = va; lk_write = w;
  endtask
  task automatic fl(input logic [3:0] c, input logic [39:0] va, input logic [27:0] pb,
                    input logic [4:0] f, input logic [3:0] attr);
    fill_valid = 1; fill_ctx = c; fill_vaddr = va; fill_pbase = pb; fill_frag = f;
    {fill_snoop, fill_sys, fill_wr, fill_rd} = attr;
  endtask
  task automatic fx(input logic [3:0] c); flush_valid = 1; flush_ctx = c; endtask

  initial begin
    clr();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur_req = "R1";
    for (int i = 0; i < 4; i++) begin lk(4'(i), 40'(i) << 14, 0); tick(); end
    cur_req = "R2";
    tick(); lk(0, 0, 0); tick(); tick(); lk(1, 0, 1); tick();
    cur_req = "R3";
    fl(1, 40'h12_3456_7000, 28'h0ABCDEF, 0, 4'b0011); tick();
    lk(1, 40'h12_3456_7ABC, 0); tick();
    lk(2, 40'h12_3456_7ABC, 0); tick();
    lk(1, 40'h12_3456_8ABC, 0); tick();
    lk(0, 40'h12_3456_7ABC, 0); tick();
    cur_req = "R4";
    fl(3, 40'h00_4000_0000, 28'h0777000, 4, 4'b0011); tick();
    lk(3, 40'h00_4000_F123, 0); tick();
    lk(3, 40'h00_4001_0000, 0); tick();
    lk(3, 40'h00_3FFF_FFFF, 0); tick();
    fl(7, 40'h00_0000_0000, 28'h0123456, 1, 4'b0001); tick();
    lk(7, 40'h00_0000_1FFF, 0); tick();
    lk(7, 40'h00_0000_2000, 0); tick();
    cur_req = "R5";
    fl(4, 40'h55_0000_0000, 28'hFFFFFFF, 28, 4'b0001); tick();
    lk(4, 40'hAB_CDEF_0123, 0); tick();
    lk(4, 40'h01_2345_6789, 0); tick();
    cur_req = "R6";
    fl(2, 40'h00_0020_0000, 28'h0000200, 0, 4'b1111); tick();
    lk(2, 40'h00_0020_0010, 1); tick();
    fl(2, 40'h00_0030_0000, 28'h0000300, 0, 4'b0101); tick();
    lk(2, 40'h00_0030_0010, 0); tick();
    cur_req = "R7";
    fl(5, 40'h00_0800_0000, 28'h0001000, 0, 4'b0001); tick();
    lk(5, 40'h00_0800_0004, 1); tick();
    lk(5, 40'h00_0800_0004, 0); tick();
    fl(5, 40'h00_0900_0000, 28'h0002000, 0, 4'b0010); tick();
    lk(5, 40'h00_0900_0004, 0); tick();
    lk(5, 40'h00_0900_0004, 1); tick();
    cur_req = "R8";
    fx(1); tick();
    lk(1, 40'h12_3456_7ABC, 0); tick();
    lk(3, 40'h00_4000_0123, 0); tick();
    cur_req = "R9";
    lk(3, 40'h00_4000_0123, 0); fx(3); tick();
    lk(3, 40'h00_4000_0123, 0); tick();
    lk(4, 40'h00_0000_0042, 0); fx(5); tick();
    lk(4, 40'h00_0000_0042, 0); tick();
    cur_req = "R11";
    lk(6, 40'h00_00A0_0000, 0); fl(6, 40'h00_00A0_0000, 28'h00000A0, 0, 4'b0011); tick();
    lk(6, 40'h00_00A0_0000, 0); tick();
    fx(6); fl(6, 40'h00_00B0_0000, 28'h00000B0, 0, 4'b0011); tick();
    lk(6, 40'h00_00B0_0000, 0); tick();
    cur_req = "R12";
    fl(8, 40'h00_0000_0000, 28'h0100000, 8, 4'b0011); tick();
    fl(8, 40'h00_0000_5000, 28'h0200005, 0, 4'b0011); tick();
    lk(8, 40'h00_0000_5123, 0); tick();
    cur_req = "R10";
    for (int i = 0; i < 20; i++) begin
      fl(9, 40'(i) << 20, 28'(i + 28'h300), 0, 4'b0011); tick();
    end
    for (int i = 0; i < 20; i++) begin lk(9, 40'(i) << 20, 0); tick(); end
    lk(8, 40'h00_0000_5123, 0); tick();
    cur_req = "R3";
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(99) < 70)
        lk(4'($urandom_range(3)), {16'h0, 12'($urandom), 12'($urandom)}, 1'($urandom));
      if ($urandom_range(99) < 25)
        fl(4'($urandom_range(3)), {16'h0, 12'($urandom), 12'h000}, 28'($urandom),
           5'($urandom_range(6)), 4'($urandom));
      if ($urandom_range(99) < 5) fx(4'($urandom_range(3)));
      tick();
    end
    tick(); tick();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule